// File: doc/BRIEF.md
# IR Pulse-Width Capture Engine

This block records the timing of a demodulated infrared receiver line so that software can decode the remote-control protocol later. The line is active-low: a low level is a mark (carrier present) and a high level is a space. A programmable divider on the system clock gives the sampling tick. A de-glitch filter accepts a new level only after it has held for a set number of ticks. Each mark and each space is then measured in ticks and stored as one saturating byte in a small capture memory, starting with a mark.

A message ends when a space lasts as long as the programmed completion limit. The engine then writes a zero byte, stops recording and raises its interrupt. Software reads back the packed capture words, acknowledges the interrupt and issues a restart, which clears the memory and re-arms the engine for the next message. All access goes through a plain single-cycle register port with valid, write, word address and data.

Top module: `ir_cap_top`

## Requirements
- R1: After reset, every readable register and every capture word reads zero and `irq` is low.
- R2: Sampling ticks occur only while both run enable (config word 0, bit 0) and measure enable (bit 1) are set. One tick comes every `TICKDIV+1` clocks, with `TICKDIV` in bits 15:0 of word 1, and every stored duration is in ticks.
- R3: `irIn` low is a mark. Capture starts at the first accepted mark, so idle time before a message is never recorded. After that, bytes alternate mark, space, mark, and each holds the number of ticks between two accepted edges.
- R4: Capture word i is at address 16+i, for i from 0 to 16. It packs entries 4i to 4i+3, with the earliest entry in bits 7:0 and the latest in bits 31:24.
- R5: A duration above 255 ticks is stored as 0xFF.
- R6: A new level is accepted only after it has been seen on `FILT` consecutive ticks, with `FILT` in bits 4:0 of word 2 and 0 treated as 1. A shorter excursion is ignored and merges into the surrounding interval.
- R7: Let `DONE` be bits 14:8 of word 0. A space that reaches `DONE*16` ticks stores a zero entry, ends the capture and sets the interrupt pending. `DONE=0` disables the timeout.
- R8: After the completion zero, no further entry is written until a restart, so all later bytes read zero.
- R9: Only the first 68 entries are kept. Later edges are discarded, but the timeout still raises the interrupt.
- R10: Writing 1 to bit 0 of word 3 clears all capture words and returns the engine to waiting for a first mark.
- R11: `irq` is the pending flag gated by bit 0 of word 4. Writing 1 to bit 0 of word 5 clears the pending flag.
- R12: Words 0, 1, 2 and 4 read back their written fields. Words 3 and 5, and all unmapped addresses, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| irIn | input | 1 | Demodulated receiver line, low = mark |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Completion interrupt |

## Verification
The capture memory is only visible through readback, so a wrong internal state shows up in the packed words, usually within one message. Typical faults are a width counter that does not reset on an edge, a filter counter that does not clear, or a pointer that keeps advancing after completion. Each of these shifts or corrupts a byte at a known position. A completion state that fails to latch appears as non-zero bytes after the zero entry once a second burst arrives. A broken pending flag shows on `irq` within a clock of the timeout or the clear write. The checker watches the hand-offs between control and datapath on every cycle: stores happen only on ticks, nothing is stored after completion, and the pending flag follows completion.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  // register word addresses
  localparam int RA_CFG     = 0;
  localparam int RA_DIV     = 1;
  localparam int RA_FILT    = 2;
  localparam int RA_RESTART = 3;
  localparam int RA_IRQEN   = 4;
  localparam int RA_IRQCLR  = 5;
  localparam int RA_CAPBASE = 16;

  localparam int ENTRY_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } capState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic               store;
    logic [ENTRY_W-1:0] value;
    logic               clear;
  } capStrobe_t;

endpackage

// File: rtl/ir_cap_regs.sv
module ir_cap_regs
  import ir_cap_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16,
  parameter int FILT_W = 5,
  parameter int DONE_W = 7,
  parameter int WORDS  = 17,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       capWord,
  output logic [IDX_W-1:0]  capIdx,
  output logic              runEn,
  output logic              widthEn,
  output logic [DONE_W-1:0] doneCount,
  output logic [DIV_W-1:0]  tickDiv,
  output logic [FILT_W-1:0] filtLen,
  output logic              restartPulse,
  input  logic              doneStb,
  output logic              irqPend,
  output logic              irqEn,
  output logic              irq
);

  logic wrAcc;
  logic rdCap;
  logic clrPulse;
  logic unusedWdata;
  logic [ADDR_W-1:0] capOff;

  assign wrAcc    = busValid && busWrite;
  assign capOff   = busAddr - ADDR_W'(RA_CAPBASE);
  assign capIdx   = capOff[IDX_W-1:0];
  assign rdCap    = (busAddr >= ADDR_W'(RA_CAPBASE)) &&
                    (busAddr <  ADDR_W'(RA_CAPBASE + WORDS));
  assign restartPulse = wrAcc && (busAddr == ADDR_W'(RA_RESTART)) && busWdata[0];
  assign clrPulse     = wrAcc && (busAddr == ADDR_W'(RA_IRQCLR)) && busWdata[0];
  assign unusedWdata  = ^busWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      widthEn   <= 1'b0;
      doneCount <= '0;
      tickDiv   <= '0;
      filtLen   <= '0;
      irqEn     <= 1'b0;
      irqPend   <= 1'b0;
    end else begin
      if (wrAcc && busAddr == ADDR_W'(RA_CFG)) begin
        runEn     <= busWdata[0];
        widthEn   <= busWdata[1];
        doneCount <= busWdata[8 +: DONE_W];
      end
      if (wrAcc && busAddr == ADDR_W'(RA_DIV))   tickDiv <= busWdata[DIV_W-1:0];
      if (wrAcc && busAddr == ADDR_W'(RA_FILT))  filtLen <= busWdata[FILT_W-1:0];
      if (wrAcc && busAddr == ADDR_W'(RA_IRQEN)) irqEn   <= busWdata[0];
      // completion wins over a simultaneous acknowledge
      if (doneStb)       irqPend <= 1'b1;
      else if (clrPulse) irqPend <= 1'b0;
    end
  end

  assign irq = irqPend && irqEn;

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (rdCap) begin
        busRdata = capWord;
      end else if (busAddr == ADDR_W'(RA_CFG)) begin
        busRdata[0]           = runEn;
        busRdata[1]           = widthEn;
        busRdata[8 +: DONE_W] = doneCount;
      end else if (busAddr == ADDR_W'(RA_DIV)) begin
        busRdata[DIV_W-1:0] = tickDiv;
      end else if (busAddr == ADDR_W'(RA_FILT)) begin
        busRdata[FILT_W-1:0] = filtLen;
      end else if (busAddr == ADDR_W'(RA_IRQEN)) begin
        busRdata[0] = irqEn;
      end
    end
  end

endmodule

// File: rtl/ir_cap_ctrl.sv
module ir_cap_ctrl
  import ir_cap_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int FILT_W   = 5,
  parameter int DONE_W   = 7,
  parameter int TO_SHIFT = 4,
  localparam int CNT_W   = DONE_W + TO_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              runEn,
  input  logic              widthEn,
  input  logic [DIV_W-1:0]  tickDiv,
  input  logic [FILT_W-1:0] filtLen,
  input  logic [DONE_W-1:0] doneCount,
  input  logic              restart,
  output logic              tick,
  output capStrobe_t        strb,
  output logic              doneStb
);

  logic [1:0]        syncQ;
  logic              samp;
  logic [DIV_W-1:0]  divCnt;
  logic              active;
  logic              lvl;
  logic [FILT_W-1:0] diffRun;
  logic [FILT_W:0]   diffNext;
  logic [FILT_W:0]   gEff;
  logic              accept;
  logic [CNT_W-1:0]  wc;
  logic [CNT_W-1:0]  wcNext;
  logic [CNT_W-1:0]  limit;
  logic              timeout;
  logic [ENTRY_W-1:0] satVal;
  capState_t         state;

  assign samp     = ~syncQ[1];
  assign active   = runEn && widthEn;
  assign tick     = active && (divCnt >= tickDiv);
  assign gEff     = (filtLen == '0) ? (FILT_W+1)'(1) : {1'b0, filtLen};
  assign diffNext = {1'b0, diffRun} + 1'b1;
  assign accept   = tick && (samp != lvl) && (diffNext >= gEff);
  assign wcNext   = (&wc) ? wc : wc + 1'b1;
  assign limit    = {doneCount, {TO_SHIFT{1'b0}}};
  assign timeout  = tick && (state == ST_RUN) && !lvl && !accept &&
                    (doneCount != '0) && (wcNext == limit);
  assign satVal   = (wcNext > CNT_W'(255)) ? 8'hFF : wcNext[ENTRY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      divCnt  <= '0;
      lvl     <= 1'b0;
      diffRun <= '0;
      wc      <= '0;
      state   <= ST_IDLE;
    end else begin
      syncQ <= {syncQ[0], irIn};
      if (!active || tick) divCnt <= '0;
      else                 divCnt <= divCnt + 1'b1;

      if (tick) begin
        if (samp != lvl) begin
          if (accept) begin
            lvl     <= samp;
            diffRun <= '0;
          end else begin
            diffRun <= diffNext[FILT_W-1:0];
          end
        end else begin
          diffRun <= '0;
        end
      end

      if (restart) begin
        state <= ST_IDLE;
        wc    <= '0;
      end else begin
        case (state)
          ST_IDLE: if (accept && samp) begin
            state <= ST_RUN;
            wc    <= '0;
          end
          ST_RUN: begin
            if (timeout)     state <= ST_DONE;
            else if (accept) wc    <= '0;
            else if (tick)   wc    <= wcNext;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.clear = restart;
    strb.store = !restart && (state == ST_RUN) && (accept || timeout);
    strb.value = timeout ? '0 : satVal;
    doneStb    = !restart && timeout;
  end

endmodule

// File: rtl/ir_cap_data.sv
module ir_cap_data
  import ir_cap_pkg::*;
#(
  parameter int ENTRIES = 68,
  localparam int WORDS  = (ENTRIES + 3) / 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int PTR_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strb,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [31:0]      rdWord
);

  logic [ENTRY_W-1:0] ents [ENTRIES];
  logic [PTR_W-1:0]   ptr;
  logic [31:0]        words [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
      ptr <= '0;
    end else if (strb.store && ptr < PTR_W'(ENTRIES)) begin
      ents[ptr] <= strb.value;
      ptr       <= ptr + 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar j = 0; j < 4; j++) begin : g_byte
      if (w * 4 + j < ENTRIES) begin : g_live
        assign words[w][j*8 +: 8] = ents[w*4 + j];
      end else begin : g_pad
        assign words[w][j*8 +: 8] = '0;
      end
    end
  end

  assign rdWord = (rdIdx < IDX_W'(WORDS)) ? words[rdIdx] : '0;

endmodule

// File: rtl/ir_cap_top.sv
module ir_cap_top
  import ir_cap_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DIV_W    = 16,
  parameter int FILT_W   = 5,
  parameter int DONE_W   = 7,
  parameter int TO_SHIFT = 4,
  parameter int ENTRIES  = 68,
  localparam int WORDS   = (ENTRIES + 3) / 4,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);

  logic              runEn;
  logic              widthEn;
  logic [DONE_W-1:0] doneCount;
  logic [DIV_W-1:0]  tickDiv;
  logic [FILT_W-1:0] filtLen;
  logic              restartPulse;
  logic              doneStb;
  logic              irqPend;
  logic              irqEn;
  logic              tick;
  logic [31:0]       capWord;
  logic [IDX_W-1:0]  capIdx;
  capStrobe_t        strb;

  ir_cap_regs #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .FILT_W(FILT_W),
    .DONE_W(DONE_W), .WORDS(WORDS)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .capWord(capWord), .capIdx(capIdx),
    .runEn(runEn), .widthEn(widthEn), .doneCount(doneCount),
    .tickDiv(tickDiv), .filtLen(filtLen), .restartPulse(restartPulse),
    .doneStb(doneStb), .irqPend(irqPend), .irqEn(irqEn), .irq(irq)
  );

  ir_cap_ctrl #(
    .DIV_W(DIV_W), .FILT_W(FILT_W), .DONE_W(DONE_W), .TO_SHIFT(TO_SHIFT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .irIn(irIn),
    .runEn(runEn), .widthEn(widthEn), .tickDiv(tickDiv),
    .filtLen(filtLen), .doneCount(doneCount), .restart(restartPulse),
    .tick(tick), .strb(strb), .doneStb(doneStb)
  );

  ir_cap_data #(
    .ENTRIES(ENTRIES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdIdx(capIdx), .rdWord(capWord)
  );

endmodule

// File: rtl/ir_cap_chk.sv
module ir_cap_chk
  import ir_cap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              tick,
  input logic              runEn,
  input logic              widthEn,
  input capStrobe_t        strb,
  input logic              doneStb,
  input logic              restartPulse,
  input logic              irqPend,
  input logic              irq
);

  logic clrWr;
  logic doneSeen;
  logic unusedChk;

  assign clrWr     = busValid && busWrite && (busAddr == ADDR_W'(RA_IRQCLR)) && busWdata[0];
  assign unusedChk = ^{busWdata[31:1], strb.value, strb.clear};

  always_ff @(posedge clk) begin
    if (!rstN)             doneSeen <= 1'b0;
    else if (restartPulse) doneSeen <= 1'b0;
    else if (doneStb)      doneSeen <= 1'b1;
  end

  // R2: sampling only while both enables are set
  a_r2_tick_gated: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (runEn && widthEn));

  // R3: entries are produced only on sampling ticks
  a_r3_store_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |-> tick);

  // R7: completion sets the pending flag
  a_r7_done_pending: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> irqPend);

  // R8: nothing is stored between completion and restart
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> !strb.store);

  // R11: acknowledge drops the interrupt line
  a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !doneStb) |=> !irq);

endmodule

bind ir_cap_top ir_cap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .tick(tick), .runEn(runEn), .widthEn(widthEn), .strb(strb),
  .doneStb(doneStb), .restartPulse(restartPulse), .irqPend(irqPend), .irq(irq)
);

// File: tb/ir_cap_top_tb.sv
`timescale 1ns/1ps
module ir_cap_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int tickP = 1;
  int limitTicks = 64;

  always #2.5 clk = ~clk;

  ir_cap_top u_dut (
    .clk(clk), .rstN(rstN), .irIn(irIn),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 6'(a); busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 6'(a);
    #1 d = busRdata;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic chkWord(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(16 + idx, d);
    check(req, d, exp);
  endtask

  task automatic chkIrq(input string req, input logic exp);
    @(negedge clk);
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic mark(input int n);
    irIn = 1'b0;
    repeat (n * tickP) @(negedge clk);
  endtask

  task automatic space(input int n);
    irIn = 1'b1;
    repeat (n * tickP) @(negedge clk);
  endtask

  task automatic finishMsg();
    space(limitTicks + 12);
  endtask

  task automatic setup(input int div, input int filt, input int done, input int en);
    wr(1, div);
    tickP = div + 1;
    limitTicks = done * 16;
    wr(2, filt);
    wr(0, (done << 8) | en);
    wr(3, 1);
    wr(5, 1);
    wr(4, 1);
    space(10);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); check("R1 cfg", d, 0);
    rd(1, d); check("R1 div", d, 0);
    rd(2, d); check("R1 filt", d, 0);
    rd(4, d); check("R1 irqen", d, 0);
    chkWord("R1 word0", 0, 0);
    chkIrq("R1 irq", 1'b0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(0, 32'h0000_0403); rd(0, d); check("R12 cfg", d, 32'h0000_0403);
    wr(1, 32'h0001_1234); rd(1, d); check("R12 div", d, 32'h0000_1234);
    wr(2, 32'h0000_00F5); rd(2, d); check("R12 filt", d, 32'h0000_0015);
    wr(4, 1);             rd(4, d); check("R12 irqen", d, 1);
    rd(3, d); check("R12 restart reads 0", d, 0);
    rd(6, d); check("R12 unmapped", d, 0);
    rd(33, d); check("R12 past last word", d, 0);
  endtask

  task automatic t_basic();
    setup(1, 1, 4, 3);
    space(20);
    mark(9); space(5); mark(3); space(7); mark(12);
    finishMsg();
    chkWord("R3 R4 word0", 0, 32'h0703_0509);
    chkWord("R4 word1", 1, 32'h0000_000C);
    chkWord("R8 word2", 2, 0);
    chkIrq("R7 irq after timeout", 1'b1);
  endtask

  task automatic t_tickdiv();
    setup(3, 1, 4, 3);
    mark(6); space(4); mark(2);
    finishMsg();
    chkWord("R2 div3 word0", 0, 32'h0002_0406);
  endtask

  task automatic t_enables();
    setup(1, 1, 4, 1);
    mark(6); space(4); mark(2);
    finishMsg();
    chkWord("R2 measure off word0", 0, 0);
    chkIrq("R2 measure off irq", 1'b0);
  endtask

  task automatic t_saturate();
    setup(1, 1, 20, 3);
    mark(300); space(300); mark(2);
    finishMsg();
    chkWord("R5 saturate", 0, 32'h0002_FFFF);
  endtask

  task automatic t_glitch();
    setup(1, 3, 4, 3);
    mark(2); space(10);
    mark(10); space(5); mark(2); space(5); mark(10);
    finishMsg();
    chkWord("R6 glitch merged", 0, 32'h000A_0C0A);
  endtask

  task automatic t_filtzero();
    setup(1, 0, 4, 3);
    mark(4); space(1); mark(4);
    finishMsg();
    chkWord("R6 filt0 as 1", 0, 32'h0004_0104);
  endtask

  task automatic t_zerofill();
    setup(1, 1, 4, 3);
    mark(5); space(6); mark(7);
    finishMsg();
    mark(10); space(10); mark(10);
    finishMsg();
    chkWord("R8 word0 kept", 0, 32'h0007_0605);
    chkWord("R8 word1 zero", 1, 0);
  endtask

  task automatic t_full();
    setup(1, 1, 4, 3);
    for (int k = 0; k < 40; k++) begin
      mark(3);
      if (k < 39) space(4);
    end
    finishMsg();
    chkWord("R9 first word", 0, 32'h0403_0403);
    chkWord("R9 last word", 16, 32'h0403_0403);
    chkIrq("R9 irq", 1'b1);
  endtask

  task automatic t_notimeout();
    setup(1, 1, 0, 3);
    mark(5);
    space(200);
    chkIrq("R7 timeout disabled", 1'b0);
    chkWord("R7 no zero", 0, 32'h0000_0005);
  endtask

  task automatic t_restart();
    setup(1, 1, 4, 3);
    mark(8);
    finishMsg();
    chkWord("R10 before", 0, 32'h0000_0008);
    wr(3, 1);
    chkWord("R10 cleared", 0, 0);
    space(5);
    mark(6); space(2); mark(3);
    finishMsg();
    chkWord("R10 recapture", 0, 32'h0003_0206);
  endtask

  task automatic t_irq();
    setup(1, 1, 4, 3);
    wr(4, 0);
    mark(4);
    finishMsg();
    chkIrq("R11 masked", 1'b0);
    wr(4, 1);
    chkIrq("R11 unmasked", 1'b1);
    wr(5, 1);
    chkIrq("R11 cleared", 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_basic();
    t_tickdiv();
    t_enables();
    t_saturate();
    t_glitch();
    t_filtzero();
    t_zerofill();
    t_full();
    t_notimeout();
    t_restart();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule